// File: doc/BRIEF.md
# Ring-Oscillator Cell Enable Decoder

This block turns a frequency tuning code into one enable bit per switchable inverter cell in a ring-oscillator stage built from 4 rows of 6 parallel cells. The code arrives as two fields: a row field that names the active row and a column field that says how many cells of that row are on. Every row below the active row is forced fully on through an override path, the active row is filled from column 0 upwards, and rows above it stay off. The code therefore acts as a two-dimensional thermometer whose value is `row*6 + col`, spanning 25 distinct steps from 0 to 24 cells.

A row stage produces a one-hot active-row select and a thermometer of override bits. A column stage produces a thermometer over the columns. A cell matrix combines them per cell, and a single register stage presents the enables so that every cell changes on one clock edge. The tuning loop that owns the code drives the two fields directly. Cell `k` of the output vector sits in row `k/6`, column `k%6`.

Top module: `osc_cell_enable_dec`

## Requirements
- R1: While reset is applied, and until the first clock edge after the synchronised reset release, `cell_en` is all zeros.
- R2: For a row field r below 4 and a column field c, bit r2*6+c2 of `cell_en` is 1 exactly when r2 < r, or r2 == r and c2 < c. All set bits therefore form a contiguous run starting at bit 0.
- R3: For any code in range, the number of enabled cells equals r*6 + c.
- R4: Raising the code by one step enables exactly one extra cell, at bit r*6+c of the old code. Lowering it by one step clears that same cell, so cells leave in exactly the reverse order.
- R5: Stepping from (r, 5) to (r+1, 0) turns on cell r*6+5, which completes row r. The fill then continues at column 0 of row r+1.
- R6: Code (0, 0) enables no cells. Code (4, 0) enables all 24 cells.
- R7: `cell_en` changes only at a rising clock edge and reflects the fields sampled at the previous rising edge, so the latency is one cycle.
- R8: A column field of 6 or more enables the whole active row. A row field of 4 or more enables all 24 cells, whatever the column field holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_code | input | 3 | Active row field of the tuning code |
| col_code | input | 3 | Number of cells on in the active row |
| cell_en | output | 24 | Registered per-cell enables, bit = row*6+col |

## Verification
A full upward sweep from 0 to 24, followed by a full downward sweep, shows that each step adds or removes exactly one cell in fill order, including every row wrap. The wrap steps separate a correct row hand-off from an off-by-one in the override or active-row decode. Scattered jumps between distant codes show that the output depends only on the present code and not on the path taken to reach it. Out-of-range column and row fields show the saturation behaviour. A check made just after each input change, before the next clock edge, shows that the output is registered.

// File: rtl/rcd_pkg.sv
package rcd_pkg;
  localparam int unsigned RCD_ROWS = 4;
  localparam int unsigned RCD_COLS = 6;

  // Width needed to carry values 0..n inclusive
  function automatic int unsigned fld_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/rcd_row_stage.sv
module rcd_row_stage #(
  parameter int unsigned ROWS = 4,
  parameter int unsigned RW   = 3
) (
  input  logic [RW-1:0]   row_code,
  output logic [ROWS-1:0] row_act,
  output logic [ROWS-1:0] row_ovr
);
  // Active row is one-hot; rows strictly below it are forced fully on.
  for (genvar i = 0; i < ROWS; i++) begin : g_row
    always_comb begin
      row_act[i] = (row_code == RW'(i));
      row_ovr[i] = (row_code >  RW'(i));
    end
  end
endmodule

// File: rtl/rcd_col_stage.sv
module rcd_col_stage #(
  parameter int unsigned COLS = 6,
  parameter int unsigned CW   = 3
) (
  input  logic [CW-1:0]   col_code,
  output logic [COLS-1:0] col_therm
);
  // Thermometer: columns 0..col_code-1 selected; saturates at full row.
  for (genvar j = 0; j < COLS; j++) begin : g_col
    always_comb col_therm[j] = (col_code > CW'(j));
  end
endmodule

// File: rtl/rcd_cell_matrix.sv
module rcd_cell_matrix #(
  parameter int unsigned ROWS = 4,
  parameter int unsigned COLS = 6,
  localparam int unsigned NCELL = ROWS * COLS
) (
  input  logic [ROWS-1:0]  row_act,
  input  logic [ROWS-1:0]  row_ovr,
  input  logic [COLS-1:0]  col_therm,
  output logic [NCELL-1:0] en_nxt
);
  for (genvar r = 0; r < ROWS; r++) begin : g_r
    for (genvar c = 0; c < COLS; c++) begin : g_c
      always_comb en_nxt[r*COLS + c] = (row_act[r] & col_therm[c]) | row_ovr[r];
    end
  end
endmodule

// File: rtl/rcd_rst_sync.sv
module rcd_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/osc_cell_enable_dec.sv
module osc_cell_enable_dec #(
  parameter int unsigned ROWS = rcd_pkg::RCD_ROWS,
  parameter int unsigned COLS = rcd_pkg::RCD_COLS,
  localparam int unsigned RW    = rcd_pkg::fld_w(ROWS),
  localparam int unsigned CW    = rcd_pkg::fld_w(COLS),
  localparam int unsigned NCELL = ROWS * COLS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RW-1:0]    row_code,
  input  logic [CW-1:0]    col_code,
  output logic [NCELL-1:0] cell_en
);
  logic             rst_sync_n;
  logic [ROWS-1:0]  row_act;
  logic [ROWS-1:0]  row_ovr;
  logic [COLS-1:0]  col_therm;
  logic [NCELL-1:0] en_nxt;
  logic             upd_en;

  rcd_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rcd_row_stage #(.ROWS(ROWS), .RW(RW)) u_row (
    .row_code (row_code),
    .row_act  (row_act),
    .row_ovr  (row_ovr)
  );

  rcd_col_stage #(.COLS(COLS), .CW(CW)) u_col (
    .col_code  (col_code),
    .col_therm (col_therm)
  );

  rcd_cell_matrix #(.ROWS(ROWS), .COLS(COLS)) u_mat (
    .row_act   (row_act),
    .row_ovr   (row_ovr),
    .col_therm (col_therm),
    .en_nxt    (en_nxt)
  );

  // Register only when the decoded pattern differs from the held one.
  always_comb upd_en = (en_nxt != cell_en);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  cell_en <= '0;
    else if (upd_en)  cell_en <= en_nxt;
  end
endmodule

// File: rtl/osc_cell_enable_dec_chk.sv
module osc_cell_enable_dec_chk #(
  parameter int unsigned ROWS = 4,
  parameter int unsigned COLS = 6,
  parameter int unsigned RW   = 3,
  parameter int unsigned CW   = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rst_sync_n,
  input logic [RW-1:0]        row_code,
  input logic [CW-1:0]        col_code,
  input logic [ROWS*COLS-1:0] cell_en
);
  logic [1:0] live;

  function automatic int eff_code(input logic [RW-1:0] r, input logic [CW-1:0] c);
    int cc;
    cc = (int'(c) > int'(COLS)) ? int'(COLS) : int'(c);
    return (int'(r) >= int'(ROWS)) ? int'(ROWS * COLS) : int'(r) * int'(COLS) + cc;
  endfunction

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)       live <= 2'd0;
    else if (live != 2'd3) live <= live + 2'd1;
  end

  // R1: outputs cleared while the port reset is low
  a_r1_reset_clear: assert property (@(posedge clk) !rst_n |-> (cell_en == '0));

  // R2: enabled cells form a contiguous run from bit 0
  a_r2_contiguous: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((cell_en & (cell_en + 1'b1)) == '0));

  // R3 / R8: cell count equals effective code of previous cycle
  a_r3_cell_count: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (live >= 2'd1) |-> ($countones(cell_en) == eff_code($past(row_code), $past(col_code))));

  // R4: a one-step rise in the code adds exactly one cell
  a_r4_single_step_up: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((live >= 2'd2) && (eff_code($past(row_code), $past(col_code)) ==
                        eff_code($past(row_code, 2), $past(col_code, 2)) + 1))
    |-> ($countones(cell_en) == $countones($past(cell_en)) + 1));

  // R7: unchanged inputs leave the registered enables unchanged
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((live >= 2'd2) && ($past(row_code) == $past(row_code, 2)) &&
     ($past(col_code) == $past(col_code, 2))) |-> $stable(cell_en));
endmodule

bind osc_cell_enable_dec osc_cell_enable_dec_chk #(
  .ROWS(ROWS), .COLS(COLS), .RW(RW), .CW(CW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rst_sync_n (rst_sync_n),
  .row_code   (row_code),
  .col_code   (col_code),
  .cell_en    (cell_en)
);

// File: tb/tb_osc_cell_enable_dec.sv
module tb_osc_cell_enable_dec;
  logic        clk;
  logic        rst_n;
  logic [2:0]  row_code;
  logic [2:0]  col_code;
  logic [23:0] cell_en;

  typedef struct {
    logic [23:0] exp;
    string       req;
  } sb_item_t;

  sb_item_t    sb[$];
  int          n_chk;
  int          n_fail;
  logic [23:0] last_exp;
  bit          done;

  osc_cell_enable_dec dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .row_code (row_code),
    .col_code (col_code),
    .cell_en  (cell_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Reference: 4x6 fill, bit = row*6+col, saturating fields (R2, R8)
  function automatic logic [23:0] model(input int r, input int c);
    logic [23:0] v;
    v = '0;
    for (int k = 0; k < 24; k++) begin
      if (r >= 4) v[k] = 1'b1;
      else if (k < r * 6) v[k] = 1'b1;
      else if ((k / 6 == r) && (k % 6 < c)) v[k] = 1'b1;
    end
    return v;
  endfunction

  task automatic check(input logic [23:0] act, input logic [23:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: apply a code at the falling edge and push the expected result
  task automatic drive(input int r, input int c, input string req);
    sb_item_t it;
    @(negedge clk);
    row_code = 3'(r);
    col_code = 3'(c);
    it.exp = model(r, c);
    it.req = req;
    sb.push_back(it);
    #2;
    check(cell_en, last_exp, "R7 (no change before clock edge)");
    last_exp = it.exp;
  endtask

  // Monitor: compare after each rising edge
  initial begin
    sb_item_t it;
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        check(cell_en, it.exp, it.req);
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL R7 watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    row_code = 3'd2;
    col_code = 3'd3;
    repeat (3) @(negedge clk);
    check(cell_en, 24'h0, "R1 (during reset)");
    rst_n = 1'b1;
    #2;
    check(cell_en, 24'h0, "R1 (just after release)");
    repeat (4) @(negedge clk);
    last_exp = model(2, 3);
    check(cell_en, last_exp, "R2 (code 2,3 after reset)");

    drive(0, 0, "R6 (code 0 no cells)");
    // Upward sweep; row wraps are the R5 steps
    for (int k = 1; k <= 24; k++)
      drive(k / 6, k % 6, (k % 6 == 0) ? "R5 (row wrap up)" : "R4 (step up)");
    drive(4, 0, "R6 (code 24 all cells)");
    // Downward sweep, reverse order
    for (int k = 23; k >= 0; k--)
      drive(k / 6, k % 6, (k % 6 == 5) ? "R4 (row unwrap down)" : "R4 (step down)");
    // Jumps between distant codes
    drive(3, 2, "R3 (jump to 20)");
    drive(0, 4, "R3 (jump to 4)");
    drive(2, 5, "R2 (partial row over two full rows)");
    drive(1, 0, "R5 (row 0 full, row 1 empty)");
    drive(1, 0, "R7 (held code)");
    // Out-of-range fields
    drive(1, 7, "R8 (column field saturates)");
    drive(0, 6, "R8 (column field 6 fills row 0)");
    drive(6, 2, "R8 (row field above range)");
    drive(4, 5, "R8 (row 4 with nonzero column)");
    drive(0, 0, "R6 (back to zero)");

    @(negedge clk);
    @(negedge clk);
    check(24'(sb.size()), 24'h0, "R7 (scoreboard drained)");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule